// File: doc/BRIEF.md
# PCI Target Bus Parity Unit

This block produces and checks the even parity that guards a PCI target's address/data and command/byte-enable lines. It watches the bus handshakes to locate the address phase and the data phases. On read data phases, when the target puts data on AD, the block drives PAR one clock later. On the address phase and on write data phases it samples PAR one clock later and compares it with parity it computed itself.

An address parity mismatch is reported on the system-error line. A write data parity mismatch is reported on the parity-error line, unless the transaction is a special cycle. Both lines are open-drain. Each one is gated by its own enable input. After a report, each line is pulled low for one clock, driven high for one clock, and then released.

The surrounding target logic supplies two inputs: the direction of the current transaction, and a flag that is high in every clock in which the target drives AD.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `parOe` is high, the 37 bits made of `parOut`, `ad` and `cbeN` as sampled one clock earlier contain an even number of ones.
- R2: An address phase is the first clock in which `frameN` is low after a clock in which `frameN` and `irdyN` were both high. A clock with `frameN` low inside a transaction is never treated as an address phase.
- R3: `parOe` goes high in the clock after a clock with `adDriveEn` high, and goes low in the clock after `adDriveEn` drops. While `parOe` is low, `parOut` is 0.
- R4: If `parIn` in the clock after an address phase differs from the parity of that address phase's `ad` and `cbeN`, and `serrEnable` is high in that clock, then `serrOe`=1 and `serrOut`=0 two clocks after the address phase.
- R5: With `serrEnable` low in the check clock, an address parity mismatch does not pull `serrOut` low.
- R6: After one clock of being pulled low with no new error, a report line is driven high (oe=1, out=1) for exactly one clock, and its output enable then goes low. A line that is not being driven reads oe=0, out=1.
- R7: On a write (`isRead`=0), every data clock with `irdyN` low is checked against `parIn` one clock later. On a mismatch with `perrEnable` high, `perrOe`=1 and `perrOut`=0 two clocks after the data clock.
- R8: If the address phase carried command `cbeN`=4'b0001 (special cycle), data parity mismatches in that transaction never pull `perrOut` low.
- R9: With `perrEnable` low in the check clock, a data parity mismatch does not pull `perrOut` low.
- R10: During a read transaction (`isRead`=1), a wrong `parIn` never pulls `perrOut` low.
- R11: While `rstN` is low, `parOe`, `perrOe` and `serrOe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| ad | input | 32 | Address/data lines as seen on the bus |
| cbeN | input | 4 | Command / byte-enable lines (active low) |
| parIn | input | 1 | PAR line as seen on the bus |
| frameN | input | 1 | FRAME# from the bus |
| irdyN | input | 1 | IRDY# from the bus |
| trdyN | input | 1 | TRDY# from the bus |
| isRead | input | 1 | Current transaction is a read |
| adDriveEn | input | 1 | Target drives AD in this clock |
| perrEnable | input | 1 | Allows parity-error reporting |
| serrEnable | input | 1 | Allows system-error reporting |
| parOut | output | 1 | PAR value to drive |
| parOe | output | 1 | PAR output enable |
| perrOut | output | 1 | Parity-error line value |
| perrOe | output | 1 | Parity-error output enable |
| serrOut | output | 1 | System-error line value |
| serrOe | output | 1 | System-error output enable |

## Verification
Each result has a fixed latency:
- Driven PAR appears one clock after the AD clock it covers.
- An error report pulls its line low two clocks after the address or data clock with the bad parity.
- The line is driven high at three clocks and released at four.

The driver task records the cycle number in which it applies each bus clock. For every result it pushes an item into the scoreboard carrying that cycle plus the latency. The monitor compares at the falling edge of exactly that cycle. Clocks where no report is allowed get explicit "not low" items, so that a missed gating shows up as a miscompare.

// File: rtl/pci_par_pkg.sv
`timescale 1ns/1ps
package pci_par_pkg;

  // Strobes the control sends to the parity datapath
  typedef struct packed {
    logic latchAddr;   // address phase: keep its parity
    logic latchWrite;  // write data clock: keep its parity
    logic latchRead;   // target drives AD: prepare PAR
    logic checkAddr;   // clock after address phase: compare
    logic checkData;   // clock after write data: compare
  } parStrobe_t;

  // Command code of a special cycle on the C/BE lines
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;

  // Open-drain report channels
  localparam int NUM_OD   = 2;
  localparam int IDX_PERR = 0;
  localparam int IDX_SERR = 1;

  typedef enum logic [1:0] {
    OD_IDLE = 2'd0,
    OD_LOW  = 2'd1,
    OD_HIGH = 2'd2
  } odState_t;

endpackage

// File: rtl/pci_par_datapath.sv
`timescale 1ns/1ps
module pci_par_datapath
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbeN,
  input  logic            parIn,
  input  parStrobe_t      strobe,
  output logic            parOut,
  output logic            parOe,
  output logic            addrMismatch,
  output logic            dataMismatch
);

  localparam int PAR_W = AD_W + BE_W;

  logic [PAR_W-1:0] parVector;
  logic             busPar;
  logic             addrParQ;
  logic             dataParQ;
  logic             parOutQ;
  logic             parOeQ;

  // Even parity: PAR makes the count of ones across all bits even
  assign parVector = {ad, cbeN};
  assign busPar    = ^parVector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrParQ <= 1'b0;
      dataParQ <= 1'b0;
    end else begin
      if (strobe.latchAddr)  addrParQ <= busPar;
      if (strobe.latchWrite) dataParQ <= busPar;
    end
  end

  // PAR drive lags the AD clock it covers by one clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOeQ  <= 1'b0;
      parOutQ <= 1'b0;
    end else begin
      parOeQ  <= strobe.latchRead;
      parOutQ <= strobe.latchRead ? busPar : 1'b0;
    end
  end

  assign parOut       = parOutQ;
  assign parOe        = parOeQ;
  assign addrMismatch = strobe.checkAddr & (parIn ^ addrParQ);
  assign dataMismatch = strobe.checkData & (parIn ^ dataParQ);

  AST_PAR_DRIVE_LAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchRead |=> parOe);                                       // R3

  AST_PAR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchRead |=> (!parOe && !parOut));                        // R3

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ((^{parOut, $past(ad), $past(cbeN)}) == 1'b0));          // R1

endmodule

// File: rtl/pci_par_od_drive.sv
`timescale 1ns/1ps
module pci_par_od_drive
  import pci_par_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic errIn,
  output logic pinOut,
  output logic pinOe
);

  odState_t stateQ;
  odState_t stateD;

  // An error restarts the low pulse; otherwise pull low -> drive high -> float
  always_comb begin
    stateD = stateQ;
    if (errIn) begin
      stateD = OD_LOW;
    end else begin
      unique case (stateQ)
        OD_LOW:  stateD = OD_HIGH;
        OD_HIGH: stateD = OD_IDLE;
        default: stateD = OD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= OD_IDLE;
    else       stateQ <= stateD;
  end

  assign pinOe  = (stateQ != OD_IDLE);
  assign pinOut = (stateQ != OD_LOW);

  AST_LOW_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && !pinOut && !errIn) |=> (pinOe && pinOut));               // R6

  AST_HIGH_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && pinOut && !errIn) |=> !pinOe);                           // R6

  AST_ERR_PULLS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    errIn |=> (pinOe && !pinOut));                                     // R6

endmodule

// File: rtl/pci_par_ctrl.sv
`timescale 1ns/1ps
module pci_par_ctrl
  import pci_par_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BE_W-1:0] cbeN,
  input  logic            frameN,
  input  logic            irdyN,
  input  logic            isRead,
  input  logic            adDriveEn,
  input  logic            perrEnable,
  input  logic            serrEnable,
  input  logic            addrMismatch,
  input  logic            dataMismatch,
  output parStrobe_t      strobe,
  output logic            perrOut,
  output logic            perrOe,
  output logic            serrOut,
  output logic            serrOe
);

  logic busIdleQ;
  logic inTransQ;
  logic specialQ;
  logic checkAddrQ;
  logic checkDataQ;
  logic addrPhase;
  logic wrCapture;
  logic busIdleNow;
  logic perrErr;
  logic serrErr;

  logic [NUM_OD-1:0] errVec;
  logic [NUM_OD-1:0] pinOutVec;
  logic [NUM_OD-1:0] pinOeVec;

  assign busIdleNow = frameN & irdyN;
  assign addrPhase  = busIdleQ & ~frameN;
  assign wrCapture  = inTransQ & ~irdyN & ~isRead;

  // Phase tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busIdleQ   <= 1'b1;
      inTransQ   <= 1'b0;
      specialQ   <= 1'b0;
      checkAddrQ <= 1'b0;
      checkDataQ <= 1'b0;
    end else begin
      busIdleQ   <= busIdleNow;
      checkAddrQ <= addrPhase;
      checkDataQ <= wrCapture;
      if (addrPhase) begin
        inTransQ <= 1'b1;
        specialQ <= (cbeN == BE_W'(CMD_SPECIAL));
      end else if (busIdleNow) begin
        inTransQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.latchAddr  = addrPhase;
    strobe.latchWrite = wrCapture;
    strobe.latchRead  = adDriveEn;
    strobe.checkAddr  = checkAddrQ;
    strobe.checkData  = checkDataQ;
  end

  // Error gating
  assign serrErr = addrMismatch & serrEnable;
  assign perrErr = dataMismatch & perrEnable & ~specialQ;

  always_comb begin
    errVec           = '0;
    errVec[IDX_PERR] = perrErr;
    errVec[IDX_SERR] = serrErr;
  end

  for (genvar g = 0; g < NUM_OD; g++) begin : gOd
    pci_par_od_drive uDrive (
      .clk    (clk),
      .rstN   (rstN),
      .errIn  (errVec[g]),
      .pinOut (pinOutVec[g]),
      .pinOe  (pinOeVec[g])
    );
  end

  assign perrOut = pinOutVec[IDX_PERR];
  assign perrOe  = pinOeVec[IDX_PERR];
  assign serrOut = pinOutVec[IDX_SERR];
  assign serrOe  = pinOeVec[IDX_SERR];

  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    addrPhase |=> !addrPhase);                                         // R2

  AST_ADDR_NOT_IN_TRANS: assert property (@(posedge clk) disable iff (!rstN)
    inTransQ |-> !(addrPhase && !$past(busIdleNow)));                  // R2

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serrOe) |-> $past(serrEnable));                              // R5

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perrOe) |-> ($past(perrEnable) && !$past(specialQ)));        // R8 R9

  AST_NO_READ_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (inTransQ && isRead) |=> !checkDataQ);                             // R10

endmodule

// File: rtl/pci_parity_unit.sv
`timescale 1ns/1ps
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbeN,
  input  logic            parIn,
  input  logic            frameN,
  input  logic            irdyN,
  input  logic            trdyN,
  input  logic            isRead,
  input  logic            adDriveEn,
  input  logic            perrEnable,
  input  logic            serrEnable,
  output logic            parOut,
  output logic            parOe,
  output logic            perrOut,
  output logic            perrOe,
  output logic            serrOut,
  output logic            serrOe
);

  parStrobe_t strobe;
  logic       addrMismatch;
  logic       dataMismatch;
  logic       trdySeen;

  // Read PAR timing follows the target's own AD drive; TRDY# only qualifies the check below
  assign trdySeen = ~trdyN;

  pci_par_ctrl #(.BE_W(BE_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cbeN         (cbeN),
    .frameN       (frameN),
    .irdyN        (irdyN),
    .isRead       (isRead),
    .adDriveEn    (adDriveEn),
    .perrEnable   (perrEnable),
    .serrEnable   (serrEnable),
    .addrMismatch (addrMismatch),
    .dataMismatch (dataMismatch),
    .strobe       (strobe),
    .perrOut      (perrOut),
    .perrOe       (perrOe),
    .serrOut      (serrOut),
    .serrOe       (serrOe)
  );

  pci_par_datapath #(.AD_W(AD_W), .BE_W(BE_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ad           (ad),
    .cbeN         (cbeN),
    .parIn        (parIn),
    .strobe       (strobe),
    .parOut       (parOut),
    .parOe        (parOe),
    .addrMismatch (addrMismatch),
    .dataMismatch (dataMismatch)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!parOe && !perrOe && !serrOe));                         // R11

  AST_READ_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (trdySeen && isRead && adDriveEn) |=> parOe);                      // R3

endmodule

// File: tb/pci_parity_unit_test.sv
`timescale 1ns/1ps
module pci_parity_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] ad;
  logic [3:0]  cbeN;
  logic        parIn, frameN, irdyN, trdyN, isRead, adDriveEn;
  logic        perrEnable, serrEnable;
  logic        parOut, parOe, perrOut, perrOe, serrOut, serrOe;

  always #2.5 clk = ~clk;

  pci_parity_unit uut (
    .clk(clk), .rstN(rstN), .ad(ad), .cbeN(cbeN), .parIn(parIn),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN), .isRead(isRead),
    .adDriveEn(adDriveEn), .perrEnable(perrEnable), .serrEnable(serrEnable),
    .parOut(parOut), .parOe(parOe), .perrOut(perrOut), .perrOe(perrOe),
    .serrOut(serrOut), .serrOe(serrOe)
  );

  // Kinds: 0 {parOe,parOut}, 1 {perrOe,perrOut}, 2 {serrOe,serrOut},
  //        3 perr pulled low, 4 serr pulled low
  typedef struct {
    int         at;
    int         kind;
    logic [1:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  bit    done    = 0;

  logic [31:0] prevAd   = '0;
  logic [3:0]  prevCbe  = '0;
  logic        prevBad  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input int kind, input logic [1:0] exp, input string req);
    item_t it;
    it.at = at; it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compare every item due in this cycle at the falling edge
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          logic [1:0] act;
          case (sb[i].kind)
            0:       act = {parOe, parOut};
            1:       act = {perrOe, perrOut};
            2:       act = {serrOe, serrOut};
            3:       act = {1'b0, perrOe & ~perrOut};
            default: act = {1'b0, serrOe & ~serrOut};
          endcase
          vectors++;
          if (act !== sb[i].exp) begin
            fails++;
            $display("FAIL %s cycle %0d kind %0d: actual %b expected %b",
                     sb[i].req, cyc, sb[i].kind, act, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  // One bus clock; PAR on the bus always covers the previous clock
  task automatic busCycle(input logic f, input logic ir, input logic tr,
                          input logic [31:0] a, input logic [3:0] be,
                          input logic drv, input logic bad);
    frameN    = f;
    irdyN     = ir;
    trdyN     = tr;
    ad        = a;
    cbeN      = be;
    adDriveEn = drv;
    parIn     = (^{prevAd, prevCbe}) ^ prevBad;
    prevAd    = a;
    prevCbe   = be;
    prevBad   = bad;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) busCycle(1'b1, 1'b1, 1'b1, 32'h0, 4'hF, 1'b0, 1'b0);
  endtask

  task automatic writeTxn(input logic [3:0] cmd, input logic addrBad, input int n,
                          input logic [7:0] badMask, input logic pe, input logic se);
    int c;
    perrEnable = pe;
    serrEnable = se;
    isRead     = 1'b0;
    c = cyc;
    busCycle(1'b0, 1'b1, 1'b1, 32'h1000_0040 + n, cmd, 1'b0, addrBad);
    if (addrBad && se) begin
      push(c + 2, 2, 2'b10, "R4");
      push(c + 3, 2, 2'b11, "R6");
      push(c + 4, 2, 2'b01, "R6");
    end else begin
      push(c + 2, 4, 2'b00, addrBad ? "R5" : "R4");
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = 32'hA5A5_0000 + i * 32'h0101_1357;
      c = cyc;
      busCycle(i == n - 1, 1'b0, 1'b0, d, 4'(i), 1'b0, badMask[i]);
      if (badMask[i]) begin
        if (pe && cmd != 4'b0001) begin
          push(c + 2, 1, 2'b10, "R7");
          if (!badMask[i + 1]) push(c + 3, 1, 2'b11, "R6");
        end else begin
          push(c + 2, 3, 2'b00, (cmd == 4'b0001) ? "R8" : "R9");
        end
        push(c + 2, 4, 2'b00, "R2");
      end else begin
        push(c + 2, 3, 2'b00, "R7");
      end
    end
    idle(5);
  endtask

  task automatic readTxn(input int n, input logic [7:0] badMask, input logic pe);
    int c;
    perrEnable = pe;
    serrEnable = 1'b1;
    isRead     = 1'b1;
    c = cyc;
    busCycle(1'b0, 1'b1, 1'b1, 32'h2000_0080, 4'b0110, 1'b0, 1'b0);
    push(c + 2, 4, 2'b00, "R4");
    c = cyc;
    busCycle(1'b0, 1'b0, 1'b1, 32'h0, 4'b0000, 1'b0, 1'b0);
    push(c + 1, 0, 2'b00, "R3");
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      logic [3:0]  be;
      d  = 32'h5A00_00FF ^ (i * 32'h0013_7001);
      be = 4'b0011 ^ 4'(i);
      c  = cyc;
      busCycle(i == n - 1, 1'b0, 1'b0, d, be, 1'b1, badMask[i]);
      push(c + 1, 0, {1'b1, ^{d, be}}, "R1");
      push(c + 2, 3, 2'b00, "R10");
    end
    c = cyc;
    busCycle(1'b1, 1'b1, 1'b1, 32'h0, 4'hF, 1'b0, 1'b0);
    push(c + 1, 0, 2'b00, "R3");
    idle(4);
  endtask

  initial begin
    rstN = 1'b0;
    perrEnable = 1'b0; serrEnable = 1'b0; isRead = 1'b0;
    frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1; adDriveEn = 1'b1;
    ad = '0; cbeN = 4'hF; parIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if ({parOe, perrOe, serrOe} !== 3'b000) begin
      fails++;
      $display("FAIL R11 reset: actual %b expected 000", {parOe, perrOe, serrOe});
    end
    @(posedge clk); #1;
    adDriveEn = 1'b0;
    rstN = 1'b1;
    idle(3);

    writeTxn(4'b0111, 1'b0, 4, 8'b0000_0100, 1'b1, 1'b1);   // R7 single data error
    writeTxn(4'b0111, 1'b1, 3, 8'b0000_0000, 1'b1, 1'b1);   // R4 address error
    writeTxn(4'b0111, 1'b1, 3, 8'b0000_0010, 1'b0, 1'b0);   // R5, R9 gated off
    writeTxn(4'b0001, 1'b0, 3, 8'b0000_0001, 1'b1, 1'b1);   // R8 special cycle
    readTxn(4, 8'b0000_0101, 1'b1);                         // R1, R3, R10
    writeTxn(4'b0111, 1'b0, 6, 8'b0010_1001, 1'b1, 1'b1);   // R7 several errors
    writeTxn(4'b0111, 1'b0, 1, 8'b0000_0001, 1'b1, 1'b0);   // R7 single-clock burst
    readTxn(2, 8'b0000_0011, 1'b1);                         // R3 short read
    idle(4);

    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule